// File: doc/BRIEF.md
# Per-Line Event Interrupt Controller

This block turns activity on a bank of input lines into a single interrupt request. Every line is synchronized to the block clock and compared against its own three-bit event selector, which picks falling edge, rising edge, either edge, low level or high level. A detected event sets that line's bit in a status register. Status bits are recorded whether or not the line is enabled, and the whole register empties when software reads it.

Software enables lines by writing ones to an enable location and disables them by writing ones to a disable location. The resulting mask is readable. The bank interrupt stays high as long as some line is both pending in status and enabled in the mask. The per-line selectors come from configuration storage outside this block and arrive as one packed vector.

Top module: `line_event_irq`

## Requirements
- R1: Selector code 0 (falling edge) sets the line's status bit once for each 1-to-0 change of the synchronized input, and never for a 0-to-1 change.
- R2: Selector code 1 (rising edge) sets the line's status bit once for each 0-to-1 change, and never for a 1-to-0 change.
- R3: Selector code 2 sets the line's status bit on every change of the synchronized input, in either direction.
- R4: Selector code 3 (low level) sets the status bit in every cycle the synchronized input is 0, so the bit is set again right after a status read while the input stays low.
- R5: Selector code 4 (high level) sets the status bit in every cycle the synchronized input is 1, with the same re-set behaviour after a read.
- R6: Selector codes 5, 6 and 7 never set a status bit, whatever the input does.
- R7: A write to offset 0x20 sets every mask bit whose write-data bit is 1 and leaves the other bits alone; a read of offset 0x28 returns the mask on rdata in the cycle after the read request; writes to 0x28 and 0x2C change nothing.
- R8: A write to offset 0x24 clears every mask bit whose write-data bit is 1 and leaves the other bits alone.
- R9: A read of offset 0x2C returns the status on rdata in the next cycle and clears every status bit, except that an event detected in the same cycle as the read stays set in status.
- R10: Status bits are set by events on masked-off lines as well as on enabled lines.
- R11: irq is 1 exactly while the bitwise AND of status and mask is non-zero.
- R12: Reset clears the mask, the status and the stored previous input sample, so an input that is already 1 when reset ends is seen as a rising change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| line_in | input | NLINES | Asynchronous line inputs |
| evt_sel | input | 3*NLINES | Per-line event selector, line n in bits 3n+2..3n |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | NLINES | Write data, one bit per line |
| rdata | output | NLINES | Read data, valid the cycle after rd_en |
| irq | output | 1 | Bank interrupt request |

## Verification
The bench builds the block with its default parameters: 32 lines, an 8-bit offset and a two-stage synchronizer, so the top bits of the mask and status words and the full three-cycle latency from a pin change to a status bit are exercised. With that latency fixed, the bench can place a status read in exactly the cycle a new event arrives and show that the event survives the clear. It also holds a line high across reset to show that the cleared previous sample produces a rising event.

// File: rtl/line_event_irq.sv
module line_event_irq #(
  parameter int NLINES      = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NLINES-1:0]     line_in,
  input  logic [3*NLINES-1:0]   evt_sel,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NLINES-1:0]     wdata,
  output logic [NLINES-1:0]     rdata,
  output logic                  irq
);
  localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_DIS = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_ST  = ADDR_W'(8'h2C);

  logic [NLINES-1:0] sync_q [SYNC_STAGES];
  logic [NLINES-1:0] prev_q, mask_q, status_q, hit;
  logic [NLINES-1:0] smp;
  logic              st_rd;

  assign smp   = sync_q[SYNC_STAGES-1];
  assign st_rd = rd_en && (addr == A_ST);
  assign irq   = |(status_q & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sync_q[i] <= '0;
      prev_q <= '0;
    end else begin
      sync_q[0] <= line_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= smp;
    end
  end

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    always_comb begin
      case (evt_sel[3*g +: 3])
        3'd0:    hit[g] = ~smp[g] &  prev_q[g];
        3'd1:    hit[g] =  smp[g] & ~prev_q[g];
        3'd2:    hit[g] =  smp[g] ^  prev_q[g];
        3'd3:    hit[g] = ~smp[g];
        3'd4:    hit[g] =  smp[g];
        default: hit[g] = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      status_q <= '0;
      rdata    <= '0;
    end else begin
      status_q <= (st_rd ? '0 : status_q) | hit;
      if (wr_en && addr == A_EN)  mask_q <= mask_q | wdata;
      if (wr_en && addr == A_DIS) mask_q <= mask_q & ~wdata;
      if (rd_en && addr == A_MSK)  rdata <= mask_q;
      else if (st_rd)              rdata <= status_q;
      else                         rdata <= '0;
    end
  end
endmodule

// File: rtl/line_event_irq_chk.sv
module line_event_irq_chk #(
  parameter int NLINES = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NLINES-1:0] wdata,
  input logic [NLINES-1:0] rdata,
  input logic [NLINES-1:0] mask,
  input logic [NLINES-1:0] status,
  input logic              irq
);
  localparam logic [ADDR_W-1:0] C_EN  = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] C_DIS = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] C_ST  = ADDR_W'(8'h2C);

  AST_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_EN) |=> ((mask & $past(wdata)) == $past(wdata))) // R7
    else $error("enable write did not set mask bits");

  AST_DIS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == C_DIS) |=> ((mask & $past(wdata)) == '0)) // R8
    else $error("disable write did not clear mask bits");

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (addr == C_EN || addr == C_DIS)) |=> $stable(mask)) // R7
    else $error("mask changed without an enable or disable write");

  AST_STATUS_RETURNED: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == C_ST) |=> (rdata == $past(status))) // R9
    else $error("status read returned wrong data");

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && addr == C_ST) |=> ((status & $past(status)) == $past(status))) // R10
    else $error("status bit lost without a read");

  AST_IRQ_PERSISTS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(rd_en && addr == C_ST) && !(wr_en && addr == C_DIS)) |=> irq) // R11
    else $error("irq dropped without read or disable");
endmodule

bind line_event_irq line_event_irq_chk #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .mask(mask_q), .status(status_q), .irq(irq)
);

// File: tb/line_event_irq_tb_top.sv
`timescale 1ns/1ps
module line_event_irq_tb_top;
  localparam int N = 32;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] line_in = '0;
  logic [3*N-1:0] evt_sel = {N{3'd7}};
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic irq;

  int n_chk = 0, n_fail = 0;
  logic [N-1:0] exp_q[$];
  string tag_q[$];
  logic rd_q = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_event_irq #(.NLINES(N), .ADDR_W(AW), .SYNC_STAGES(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .evt_sel(evt_sel),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  always @(posedge clk) rd_q <= rd_en;

  always @(negedge clk) begin
    if (rd_q && exp_q.size() > 0) begin
      logic [N-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  task automatic wait_n(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [N-1:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [N-1:0] e, string t);
    rd_en = 1'b1; addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic irq_chk(logic e, string t);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic sel(int ln, logic [2:0] c);
    evt_sel[3*ln +: 3] = c;
  endtask

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R12: reset state
    irq_chk(1'b0, "R12 reset irq");
    rd_chk(8'h28, '0, "R12 reset mask");
    rd_chk(8'h2C, '0, "R12 reset status");

    // R6: codes 5..7 detect nothing
    sel(0, 3'd5); sel(1, 3'd6); sel(2, 3'd7);
    line_in[2:0] = 3'b111; wait_n(5);
    rd_chk(8'h2C, '0, "R6 reserved codes rise");
    line_in[2:0] = 3'b000; wait_n(5);
    rd_chk(8'h2C, '0, "R6 reserved codes fall");

    // R1 R2 R3 edge modes
    sel(0, 3'd0); sel(1, 3'd1); sel(2, 3'd2);
    line_in[2:0] = 3'b111; wait_n(5);
    rd_chk(8'h2C, 32'h6, "R2 R3 rising pattern, R1 no fall");
    line_in[2:0] = 3'b000; wait_n(5);
    rd_chk(8'h2C, 32'h5, "R1 R3 falling pattern, R2 no rise");

    // R10 R11 R7 R8 masking
    line_in[1] = 1'b1; wait_n(5);
    irq_chk(1'b0, "R10 masked event no irq");
    wr(8'h20, 32'h2);
    irq_chk(1'b1, "R11 irq after enable");
    rd_chk(8'h28, 32'h2, "R7 mask readback");
    rd_chk(8'h2C, 32'h2, "R10 masked event latched");
    irq_chk(1'b0, "R9 R11 irq low after clear");
    wr(8'h20, 32'h10);
    rd_chk(8'h28, 32'h12, "R7 zero bits ignored on enable");
    wr(8'h24, 32'h2);
    rd_chk(8'h28, 32'h10, "R8 disable clears");
    wr(8'h24, 32'h0);
    rd_chk(8'h28, 32'h10, "R8 zero disable ignored");
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'h2C, 32'hFFFF_FFFF);
    rd_chk(8'h28, 32'h10, "R7 write to mask and status offsets ignored");
    rd_chk(8'h2C, 32'h0, "R7 status untouched by write");

    // R4 low level
    sel(3, 3'd3); wait_n(2);
    rd_chk(8'h2C, 32'h8, "R4 low level");
    rd_chk(8'h2C, 32'h8, "R4 low level re-sets after read");
    line_in[3] = 1'b1; wait_n(5);
    rd_chk(8'h2C, 32'h8, "R4 pending from low period");
    rd_chk(8'h2C, 32'h0, "R4 quiet when high");
    sel(3, 3'd7);

    // R5 high level
    sel(4, 3'd4); line_in[4] = 1'b1; wait_n(5);
    irq_chk(1'b1, "R11 enabled high level irq");
    rd_chk(8'h2C, 32'h10, "R5 high level");
    rd_chk(8'h2C, 32'h10, "R5 high level re-sets after read");
    line_in[4] = 1'b0; wait_n(5);
    rd_chk(8'h2C, 32'h10, "R5 pending from high period");
    rd_chk(8'h2C, 32'h0, "R5 quiet when low");
    irq_chk(1'b0, "R11 irq low when nothing pending");
    sel(4, 3'd7);

    // R9 event in the same cycle as a status read
    line_in[1] = 1'b0; wait_n(5);
    rd_chk(8'h2C, 32'h0, "R2 no event on fall");
    line_in[1] = 1'b1;
    wait_n(2);
    rd_chk(8'h2C, 32'h0, "R9 read in event cycle returns old status");
    rd_chk(8'h2C, 32'h2, "R9 same-cycle event kept");

    // R12 reset mid-run, previous sample cleared
    wr(8'h20, 32'hFF);
    rst_n = 1'b0; wait_n(2);
    rst_n = 1'b1;
    irq_chk(1'b0, "R12 irq after reset");
    rd_chk(8'h28, 32'h0, "R12 mask cleared");
    rd_chk(8'h2C, 32'h0, "R12 status cleared");
    wait_n(3);
    rd_chk(8'h2C, 32'h2, "R12 previous sample cleared, rise seen");

    wait_n(2);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule